// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache with Line-Size Bypass

This block sits between a processor-side load/store port and a backing memory that only moves whole 32-byte lines. It holds 20 sets of two ways each, 1280 bytes of data in all, and runs write-back with one dirty bit per line. The set count is not a power of two, so the line address is split by division: the remainder modulo 20 picks the set and the quotient is kept as the tag. Both loads and stores that miss bring the line in. A dirty victim goes out to memory before the refill is requested.

A processor request of exactly one full line is treated as a bulk transfer. It goes straight to the backing port and never allocates. The cached copy is kept consistent: a bulk store that finds the line resident rewrites it and leaves it clean. A bulk load that finds a dirty copy is answered from the cache. A flush input writes every dirty line back, then drops all valid bits in a single cycle.

Top module: `assoc2_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1, and `cpu_done`, `flush_done` and `mem_req_valid` are 0. Each request produces exactly one single-cycle `cpu_done` pulse.
- R2: A load that misses fetches the line with one backing read (`mem_req_we`=0). A following load anywhere in the same line causes no backing traffic.
- R3: A store that misses fetches the line with one backing read and no backing write. A load of the stored bytes then returns them with no backing traffic.
- R4: The line address is `cpu_addr >> 5`. The set is the line address modulo 20, so lines L, L+20 and L+40 compete for the same two ways.
- R5: When the victim line is dirty, its backing write (carrying the victim's own line address) is issued before the backing read of the missing line.
- R6: A set with an empty way fills that way first. With both ways valid, the less recently used way is replaced.
- R7: `cpu_size`=3 (32 bytes) is a bulk transfer. A bulk load that does not hit a dirty line is served by one backing read and does not allocate.
- R8: A bulk store is always written to backing memory. If the line is resident, its cached copy takes the new data.
- R9: A bulk load of a resident dirty line returns the cached data with no backing traffic.
- R10: A `flush_req` pulse writes back every dirty line and then invalidates all lines. Afterwards backing memory matches the processor's view, and any load misses.
- R11: `cpu_size` 0, 1 and 2 select 1, 2 and 4 bytes, naturally aligned. Write data sits in the low bytes of `cpu_wdata` and load data in the low bytes of `cpu_rdata`, little-endian from `cpu_addr`. Only the addressed bytes change.
- R12: Once `mem_req_valid` is raised, it stays high with a stable line address, write flag and data until `mem_req_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request accepted this cycle when high together with cpu_valid |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: 32-byte bulk |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 256 | Store data, low bytes for small accesses |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 256 | Load data, valid with cpu_done |
| flush_req | input | 1 | Start write-back-and-invalidate of the whole cache |
| flush_done | output | 1 | One-cycle pulse when the flush has finished |
| mem_req_valid | output | 1 | Backing request present |
| mem_req_ready | input | 1 | Backing memory accepts the request |
| mem_req_we | output | 1 | 1: line write, 0: line read |
| mem_req_line | output | 27 | Line address (byte address >> 5) |
| mem_req_wdata | output | 256 | Line data for writes |
| mem_rsp_valid | input | 1 | Read line data present |
| mem_rsp_data | input | 256 | Read line data |

## Verification
The bench targets the modulo-20 conflict set with lines 7, 27 and 47. Power-of-two indexing would scatter these lines and never evict. An inverted LRU bit would throw out the line just touched, and a later load would show an unexpected backing read. A dirty eviction is checked for write-before-read order and for the victim's rebuilt line address. Getting the tag or the quotient wrong would write the victim to the wrong place in backing memory. The bulk cases check three things: a bulk load does not allocate, a bulk store refreshes a resident copy, and a bulk load of a dirty line is served from the cache without going stale. The flush check compares all of backing memory with the processor's view, so a skipped dirty line shows up as a mismatch.

// File: rtl/assoc2_cache_pkg.sv
package assoc2_cache_pkg;

  localparam int unsigned LINE_BYTES_DEF = 32;
  localparam logic [1:0]  SIZE_BULK      = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_BP_WR,
    ST_BP_RD,
    ST_BP_WAIT,
    ST_FL_SCAN,
    ST_FL_WB,
    ST_FL_CLEAR
  } cache_state_e;

  // remainder of the line address picks the set
  function automatic logic [31:0] set_of(input logic [31:0] line, input int unsigned nsets);
    return line % nsets;
  endfunction

  // quotient of the line address is the stored tag
  function automatic logic [31:0] tag_of(input logic [31:0] line, input int unsigned nsets);
    return line / nsets;
  endfunction

  // inverse of the split above
  function automatic logic [31:0] line_of(input logic [31:0] tag, input logic [31:0] set,
                                          input int unsigned nsets);
    return tag * nsets + set;
  endfunction

  function automatic int unsigned size_bytes(input logic [1:0] sz, input int unsigned line_bytes);
    if (sz == SIZE_BULK) return line_bytes;
    return 1 << sz;
  endfunction

endpackage

// File: rtl/cache_tags.sv
module cache_tags #(
  parameter int unsigned NSETS = 20,
  parameter int unsigned TAG_W = 27,
  parameter int unsigned SET_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SET_W-1:0]      rd_set,
  output logic [1:0]            rd_valid,
  output logic [1:0]            rd_dirty,
  output logic [1:0][TAG_W-1:0] rd_tag,
  output logic                  rd_lru,
  input  logic                  wr_en,
  input  logic [SET_W-1:0]      wr_set,
  input  logic                  wr_way,
  input  logic                  wr_dirty,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic                  lru_en,
  input  logic [SET_W-1:0]      lru_set,
  input  logic                  lru_val,
  input  logic                  clear_all,
  output logic                  any_dirty
);
  logic [NSETS-1:0] lru_q;
  logic [1:0]       way_dirty;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [NSETS-1:0] valid_q;
    logic [NSETS-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [NSETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (clear_all) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (wr_en && (wr_way == 1'(w))) begin
        valid_q[wr_set] <= 1'b1;
        dirty_q[wr_set] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) tag_q[wr_set] <= wr_tag;
    end

    assign rd_valid[w]  = valid_q[rd_set];
    assign rd_dirty[w]  = dirty_q[rd_set] & valid_q[rd_set];
    assign rd_tag[w]    = tag_q[rd_set];
    assign way_dirty[w] = |(dirty_q & valid_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q <= '0;
    else if (lru_en) lru_q[lru_set] <= lru_val;
  end

  assign rd_lru    = lru_q[rd_set];
  assign any_dirty = |way_dirty;

  // invalidating while modified data is still held would lose stores
  AST_FLUSH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |-> !any_dirty); // R10

endmodule

// File: rtl/cache_lines.sv
module cache_lines #(
  parameter int unsigned NSETS     = 20,
  parameter int unsigned LINE_BITS = 256,
  parameter int unsigned SET_W     = 5
) (
  input  logic                      clk,
  input  logic [SET_W-1:0]          rd_set,
  output logic [1:0][LINE_BITS-1:0] rd_line,
  input  logic                      wr_en,
  input  logic [SET_W-1:0]          wr_set,
  input  logic                      wr_way,
  input  logic [LINE_BITS-1:0]      wr_data
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [LINE_BITS-1:0] data_q [NSETS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) data_q[wr_set] <= wr_data;
    end

    assign rd_line[w] = data_q[rd_set];
  end
endmodule

// File: rtl/cache_match.sv
module cache_match #(
  parameter int unsigned TAG_W = 27
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  check_en,
  input  logic [1:0]            valid,
  input  logic [1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      req_tag,
  input  logic                  lru,
  output logic [1:0]            hit_vec,
  output logic                  hit,
  output logic                  hit_way,
  output logic                  victim_way
);
  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == req_tag);
  end

  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];

  // an empty way is taken before any valid one
  always_comb begin
    if (!valid[0])      victim_way = 1'b0;
    else if (!valid[1]) victim_way = 1'b1;
    else                victim_way = lru;
  end

  // a line may live in only one way of its set
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    check_en |-> $onehot0(hit_vec)); // R4

endmodule

// File: rtl/assoc2_cache.sv
module assoc2_cache
  import assoc2_cache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NSETS      = 20,
  parameter int unsigned LINE_BYTES = LINE_BYTES_DEF
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      cpu_valid,
  output logic                                      cpu_ready,
  input  logic                                      cpu_we,
  input  logic [1:0]                                cpu_size,
  input  logic [ADDR_W-1:0]                         cpu_addr,
  input  logic [LINE_BYTES*8-1:0]                   cpu_wdata,
  output logic                                      cpu_done,
  output logic [LINE_BYTES*8-1:0]                   cpu_rdata,
  input  logic                                      flush_req,
  output logic                                      flush_done,
  output logic                                      mem_req_valid,
  input  logic                                      mem_req_ready,
  output logic                                      mem_req_we,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]      mem_req_line,
  output logic [LINE_BYTES*8-1:0]                   mem_req_wdata,
  input  logic                                      mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]                   mem_rsp_data
);
  localparam int unsigned LINE_BITS = LINE_BYTES * 8;
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES);
  localparam int unsigned LINE_W    = ADDR_W - OFF_W;
  localparam int unsigned SET_W     = $clog2(NSETS);
  localparam int unsigned TAG_W     = LINE_W;

  // ---------------- arithmetic helpers ----------------
  function automatic logic [LINE_BITS-1:0] merge_bytes(input logic [LINE_BITS-1:0] old,
                                                       input logic [LINE_BITS-1:0] wd,
                                                       input logic [OFF_W-1:0]     off,
                                                       input int unsigned          n);
    logic [LINE_BITS-1:0] res;
    res = old;
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (b >= int'(off) && b < int'(off) + int'(n))
        res[b*8 +: 8] = wd[(b - int'(off))*8 +: 8];
    end
    return res;
  endfunction

  function automatic logic [LINE_BITS-1:0] pick_bytes(input logic [LINE_BITS-1:0] line,
                                                      input logic [OFF_W-1:0]     off,
                                                      input int unsigned          n);
    logic [LINE_BITS-1:0] res;
    res = '0;
    for (int b = 0; b < 4; b++) begin
      if (b < int'(n) && int'(off) + b < LINE_BYTES)
        res[b*8 +: 8] = line[(int'(off) + b)*8 +: 8];
    end
    return res;
  endfunction

  // ---------------- request registers ----------------
  cache_state_e         state_q, state_d;
  logic                 r_we;
  logic [1:0]           r_size;
  logic [ADDR_W-1:0]    r_addr;
  logic [LINE_BITS-1:0] r_wdata;
  logic                 r_vway;
  logic [SET_W-1:0]     fl_set;
  logic                 fl_way;

  logic [LINE_W-1:0]    r_line;
  logic [SET_W-1:0]     r_set;
  logic [TAG_W-1:0]     r_tag;
  logic [OFF_W-1:0]     r_off;
  logic                 r_bulk;
  int unsigned          r_nbytes;

  assign r_line   = r_addr[ADDR_W-1:OFF_W];
  assign r_set    = SET_W'(set_of(32'(r_line), NSETS));
  assign r_tag    = TAG_W'(tag_of(32'(r_line), NSETS));
  assign r_off    = r_addr[OFF_W-1:0];
  assign r_bulk   = (r_size == SIZE_BULK);
  assign r_nbytes = size_bytes(r_size, LINE_BYTES);

  // ---------------- storage ----------------
  logic                      in_flush;
  logic [SET_W-1:0]          rd_set;
  logic [1:0]                t_valid, t_dirty;
  logic [1:0][TAG_W-1:0]     t_tag;
  logic                      t_lru;
  logic                      tw_en, tw_way, tw_dirty;
  logic [SET_W-1:0]          tw_set;
  logic [TAG_W-1:0]          tw_tag;
  logic                      lru_en, lru_val;
  logic                      clear_all, any_dirty;
  logic [1:0][LINE_BITS-1:0] d_line;
  logic                      dw_en, dw_way;
  logic [LINE_BITS-1:0]      dw_data;
  logic [1:0]                hit_vec;
  logic                      hit, hit_way, victim_way;

  assign in_flush = (state_q == ST_FL_SCAN) || (state_q == ST_FL_WB) || (state_q == ST_FL_CLEAR);
  assign rd_set   = in_flush ? fl_set : r_set;

  cache_tags #(.NSETS(NSETS), .TAG_W(TAG_W), .SET_W(SET_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .rd_set(rd_set),
    .rd_valid(t_valid), .rd_dirty(t_dirty), .rd_tag(t_tag), .rd_lru(t_lru),
    .wr_en(tw_en), .wr_set(tw_set), .wr_way(tw_way), .wr_dirty(tw_dirty), .wr_tag(tw_tag),
    .lru_en(lru_en), .lru_set(r_set), .lru_val(lru_val),
    .clear_all(clear_all), .any_dirty(any_dirty)
  );

  cache_lines #(.NSETS(NSETS), .LINE_BITS(LINE_BITS), .SET_W(SET_W)) u_lines (
    .clk(clk), .rd_set(rd_set), .rd_line(d_line),
    .wr_en(dw_en), .wr_set(tw_set), .wr_way(dw_way), .wr_data(dw_data)
  );

  cache_match #(.TAG_W(TAG_W)) u_match (
    .clk(clk), .rst_n(rst_n), .check_en(state_q == ST_CHECK),
    .valid(t_valid), .tags(t_tag), .req_tag(r_tag), .lru(t_lru),
    .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way), .victim_way(victim_way)
  );

  // ---------------- named events for the assertions ----------------
  logic ev_alloc, ev_fill_issue, ev_flush_clear, ev_accept;
  assign ev_alloc       = (state_q == ST_FILL_WAIT) && mem_rsp_valid;
  assign ev_fill_issue  = (state_q == ST_FILL_REQ);
  assign ev_flush_clear = (state_q == ST_FL_CLEAR);
  assign ev_accept      = cpu_valid && cpu_ready;

  // ---------------- control ----------------
  logic                 respond;
  logic [LINE_BITS-1:0] resp_data;
  logic                 fl_adv;
  logic                 take_victim;

  assign cpu_ready = (state_q == ST_IDLE) && !flush_req;

  always_comb begin
    state_d       = state_q;
    tw_en         = 1'b0;
    tw_set        = r_set;
    tw_way        = 1'b0;
    tw_dirty      = 1'b0;
    tw_tag        = r_tag;
    dw_en         = 1'b0;
    dw_way        = 1'b0;
    dw_data       = r_wdata;
    lru_en        = 1'b0;
    lru_val       = 1'b0;
    clear_all     = 1'b0;
    respond       = 1'b0;
    resp_data     = '0;
    fl_adv        = 1'b0;
    take_victim   = 1'b0;
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_line  = r_line;
    mem_req_wdata = r_wdata;

    unique case (state_q)
      ST_IDLE: begin
        if (flush_req)      state_d = ST_FL_SCAN;
        else if (cpu_valid) state_d = ST_CHECK;
      end

      ST_CHECK: begin
        if (r_bulk) begin
          if (r_we) begin
            if (hit) begin
              // refresh the resident copy; memory gets the same bytes
              tw_en   = 1'b1; tw_way = hit_way; tw_dirty = 1'b0;
              dw_en   = 1'b1; dw_way = hit_way; dw_data  = r_wdata;
              lru_en  = 1'b1; lru_val = ~hit_way;
            end
            state_d = ST_BP_WR;
          end else if (hit && t_dirty[hit_way]) begin
            respond   = 1'b1;
            resp_data = d_line[hit_way];
            state_d   = ST_IDLE;
          end else begin
            state_d = ST_BP_RD;
          end
        end else if (hit) begin
          lru_en  = 1'b1;
          lru_val = ~hit_way;
          respond = 1'b1;
          if (r_we) begin
            tw_en   = 1'b1; tw_way = hit_way; tw_dirty = 1'b1;
            dw_en   = 1'b1; dw_way = hit_way;
            dw_data = merge_bytes(d_line[hit_way], r_wdata, r_off, r_nbytes);
          end else begin
            resp_data = pick_bytes(d_line[hit_way], r_off, r_nbytes);
          end
          state_d = ST_IDLE;
        end else begin
          take_victim = 1'b1;
          state_d = (t_valid[victim_way] && t_dirty[victim_way]) ? ST_WB : ST_FILL_REQ;
        end
      end

      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_line  = LINE_W'(line_of(32'(t_tag[r_vway]), 32'(r_set), NSETS));
        mem_req_wdata = d_line[r_vway];
        if (mem_req_ready) begin
          tw_en = 1'b1; tw_way = r_vway; tw_dirty = 1'b0; tw_tag = t_tag[r_vway];
          state_d = ST_FILL_REQ;
        end
      end

      ST_FILL_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_FILL_WAIT;
      end

      ST_FILL_WAIT: begin
        if (mem_rsp_valid) begin
          tw_en = 1'b1; tw_way = r_vway; tw_dirty = 1'b0;
          dw_en = 1'b1; dw_way = r_vway; dw_data = mem_rsp_data;
          state_d = ST_CHECK;
        end
      end

      ST_BP_WR: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        if (mem_req_ready) begin
          respond = 1'b1;
          state_d = ST_IDLE;
        end
      end

      ST_BP_RD: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_BP_WAIT;
      end

      ST_BP_WAIT: begin
        if (mem_rsp_valid) begin
          respond   = 1'b1;
          resp_data = mem_rsp_data;
          state_d   = ST_IDLE;
        end
      end

      ST_FL_SCAN: begin
        if (t_dirty[fl_way]) begin
          state_d = ST_FL_WB;
        end else begin
          fl_adv = 1'b1;
          if (fl_way && (fl_set == SET_W'(NSETS - 1))) state_d = ST_FL_CLEAR;
        end
      end

      ST_FL_WB: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_line  = LINE_W'(line_of(32'(t_tag[fl_way]), 32'(fl_set), NSETS));
        mem_req_wdata = d_line[fl_way];
        if (mem_req_ready) begin
          tw_en = 1'b1; tw_set = fl_set; tw_way = fl_way; tw_dirty = 1'b0;
          tw_tag = t_tag[fl_way];
          fl_adv = 1'b1;
          state_d = (fl_way && (fl_set == SET_W'(NSETS - 1))) ? ST_FL_CLEAR : ST_FL_SCAN;
        end
      end

      ST_FL_CLEAR: begin
        clear_all = 1'b1;
        state_d   = ST_IDLE;
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      r_we       <= 1'b0;
      r_size     <= '0;
      r_addr     <= '0;
      r_wdata    <= '0;
      r_vway     <= 1'b0;
      fl_set     <= '0;
      fl_way     <= 1'b0;
      cpu_done   <= 1'b0;
      cpu_rdata  <= '0;
      flush_done <= 1'b0;
    end else begin
      state_q    <= state_d;
      cpu_done   <= respond;
      flush_done <= ev_flush_clear;
      if (respond) cpu_rdata <= resp_data;
      if (ev_accept) begin
        r_we    <= cpu_we;
        r_size  <= cpu_size;
        r_addr  <= cpu_addr;
        r_wdata <= cpu_wdata;
      end
      if (take_victim) r_vway <= victim_way;
      if ((state_q == ST_IDLE) && flush_req) begin
        fl_set <= '0;
        fl_way <= 1'b0;
      end else if (fl_adv) begin
        fl_way <= ~fl_way;
        if (fl_way) fl_set <= (fl_set == SET_W'(NSETS - 1)) ? '0 : fl_set + 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_line) && $stable(mem_req_we) && $stable(mem_req_wdata))); // R12

  AST_FILL_AFTER_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_issue |-> !(t_valid[r_vway] && t_dirty[r_vway])); // R5

  AST_NO_BULK_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |-> !r_bulk); // R7

  AST_SMALL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && cpu_size != SIZE_BULK) |->
      ((cpu_addr & ADDR_W'(size_bytes(cpu_size, LINE_BYTES) - 1)) == '0)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R1

endmodule

// File: tb/assoc2_cache_test.sv
module assoc2_cache_test;
  localparam int NL = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_valid = 1'b0;
  logic         cpu_ready;
  logic         cpu_we = 1'b0;
  logic [1:0]   cpu_size = '0;
  logic [31:0]  cpu_addr = '0;
  logic [255:0] cpu_wdata = '0;
  logic         cpu_done;
  logic [255:0] cpu_rdata;
  logic         flush_req = 1'b0;
  logic         flush_done;
  logic         mem_req_valid;
  logic         mem_req_ready;
  logic         mem_req_we;
  logic [26:0]  mem_req_line;
  logic [255:0] mem_req_wdata;
  logic         mem_rsp_valid = 1'b0;
  logic [255:0] mem_rsp_data = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  assoc2_cache uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .flush_req(flush_req), .flush_done(flush_done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_line(mem_req_line), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // ---------------- backing memory model ----------------
  logic [255:0] mem_img [NL];
  logic [255:0] gold [NL];
  logic [7:0]   rdy_cnt = '0;
  logic         pend = 1'b0;
  int           pend_wait = 0;
  logic [7:0]   pend_line = '0;
  logic         log_we [64];
  logic [26:0]  log_line [64];
  int           log_n = 0;

  assign mem_req_ready = (rdy_cnt[1:0] != 2'd3);

  initial begin
    for (int l = 0; l < NL; l++) begin
      for (int b = 0; b < 32; b++) begin
        mem_img[l][b*8 +: 8] = 8'((l * 13 + b * 7 + 1) & 8'hff);
        gold[l][b*8 +: 8]    = 8'((l * 13 + b * 7 + 1) & 8'hff);
      end
    end
  end

  always @(posedge clk) begin
    rdy_cnt       <= rdy_cnt + 8'd1;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (pend_wait == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_img[pend_line];
        pend          <= 1'b0;
      end else begin
        pend_wait <= pend_wait - 1;
      end
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      log_we[log_n % 64]   <= mem_req_we;
      log_line[log_n % 64] <= mem_req_line;
      log_n                <= log_n + 1;
      if (mem_req_we) mem_img[mem_req_line[7:0]] <= mem_req_wdata;
      else begin
        pend      <= 1'b1;
        pend_wait <= 1;
        pend_line <= mem_req_line[7:0];
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gold_bytes(input int line, input int off, input int n);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < n; b++) r[b*8 +: 8] = gold[line][(off + b)*8 +: 8];
    return r;
  endfunction

  task automatic cpu_op(input logic we, input logic [1:0] sz, input int line, input int off,
                        input logic [255:0] wd, output logic [255:0] rd);
    int t;
    int n;
    n = (sz == 2'd3) ? 32 : (1 << sz);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_size = sz;
    cpu_addr = 32'(line * 32 + off); cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 1'b0;
    t = 0;
    while (!cpu_done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 2000) chk(1'b0, "R1 response timeout", 64'(t), 64'd0);
    rd = cpu_rdata;
    if (we) for (int b = 0; b < n; b++) gold[line][(off + b)*8 +: 8] = wd[b*8 +: 8];
  endtask

  function automatic int traffic(input int base);
    return log_n - base;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(cpu_ready == 1'b1, "R1 ready after reset", 64'(cpu_ready), 64'd1);
    chk(!cpu_done && !flush_done && !mem_req_valid, "R1 idle outputs after reset",
        64'({cpu_done, flush_done, mem_req_valid}), 64'd0);
  endtask

  task automatic t_read_alloc();
    logic [255:0] rd;
    int base;
    base = log_n;
    cpu_op(1'b0, 2'd2, 3, 8, '0, rd);
    chk(rd[31:0] == gold_bytes(3, 8, 4), "R2 miss data", 64'(rd[31:0]), 64'(gold_bytes(3, 8, 4)));
    chk(traffic(base) == 1 && log_we[base % 64] == 1'b0 && log_line[base % 64] == 27'd3,
        "R2 one line read", 64'(traffic(base)), 64'd1);
    base = log_n;
    cpu_op(1'b0, 2'd2, 3, 12, '0, rd);
    chk(traffic(base) == 0, "R2 same-line hit silent", 64'(traffic(base)), 64'd0);
    chk(rd[31:0] == gold_bytes(3, 12, 4), "R2 hit data", 64'(rd[31:0]), 64'(gold_bytes(3, 12, 4)));
  endtask

  task automatic t_sizes();
    logic [255:0] rd;
    int base;
    logic [7:0] b4;
    b4 = gold[3][4*8 +: 8];
    base = log_n;
    cpu_op(1'b1, 2'd0, 3, 5, 256'h5A, rd);
    cpu_op(1'b1, 2'd1, 3, 6, 256'hBEEF, rd);
    cpu_op(1'b0, 2'd2, 3, 4, '0, rd);
    chk(rd[31:0] == {8'hBE, 8'hEF, 8'h5A, b4}, "R11 byte lanes merge",
        64'(rd[31:0]), 64'({8'hBE, 8'hEF, 8'h5A, b4}));
    chk(traffic(base) == 0, "R11 small ops hit", 64'(traffic(base)), 64'd0);
    cpu_op(1'b0, 2'd0, 3, 8, '0, rd);
    chk(rd[31:0] == {24'd0, gold[3][8*8 +: 8]}, "R11 single byte read zero-extended",
        64'(rd[31:0]), 64'({24'd0, gold[3][8*8 +: 8]}));
  endtask

  task automatic t_write_alloc();
    logic [255:0] rd;
    int base;
    base = log_n;
    cpu_op(1'b1, 2'd2, 50, 0, 256'hCAFEF00D, rd);
    chk(traffic(base) == 1 && log_we[base % 64] == 1'b0, "R3 store miss fills without write",
        64'(traffic(base)), 64'd1);
    base = log_n;
    cpu_op(1'b0, 2'd2, 50, 0, '0, rd);
    chk(rd[31:0] == 32'hCAFEF00D && traffic(base) == 0, "R3 stored word read back",
        64'(rd[31:0]), 64'hCAFEF00D);
  endtask

  task automatic t_set_map();
    logic [255:0] rd;
    int base;
    // lines 7, 27 and 47 share one set under modulo-20 indexing
    base = log_n;
    cpu_op(1'b0, 2'd2, 7, 0, '0, rd);
    cpu_op(1'b0, 2'd2, 27, 0, '0, rd);
    chk(traffic(base) == 2, "R4 two fills", 64'(traffic(base)), 64'd2);
    base = log_n;
    cpu_op(1'b0, 2'd2, 7, 4, '0, rd);
    cpu_op(1'b0, 2'd2, 27, 4, '0, rd);
    chk(traffic(base) == 0, "R6 empty way used first, both resident", 64'(traffic(base)), 64'd0);
    cpu_op(1'b0, 2'd2, 7, 8, '0, rd);
    base = log_n;
    cpu_op(1'b0, 2'd2, 47, 0, '0, rd);
    chk(traffic(base) == 1 && log_line[base % 64] == 27'd47, "R4 third line in set misses",
        64'(traffic(base)), 64'd1);
    base = log_n;
    cpu_op(1'b0, 2'd2, 7, 0, '0, rd);
    chk(traffic(base) == 0, "R6 recently used line kept", 64'(traffic(base)), 64'd0);
    base = log_n;
    cpu_op(1'b0, 2'd2, 27, 0, '0, rd);
    chk(traffic(base) == 1, "R6 least recent line was evicted", 64'(traffic(base)), 64'd1);
    chk(rd[31:0] == gold_bytes(27, 0, 4), "R4 refetched data", 64'(rd[31:0]), 64'(gold_bytes(27, 0, 4)));
  endtask

  task automatic t_dirty_wb();
    logic [255:0] rd;
    int base;
    cpu_op(1'b1, 2'd2, 12, 0, 256'h11223344, rd);
    cpu_op(1'b1, 2'd2, 32, 4, 256'h55667788, rd);
    base = log_n;
    cpu_op(1'b0, 2'd2, 52, 0, '0, rd);
    chk(traffic(base) == 2, "R5 writeback plus fill", 64'(traffic(base)), 64'd2);
    chk(log_we[base % 64] == 1'b1 && log_line[base % 64] == 27'd12, "R5 victim written first",
        64'({log_we[base % 64], log_line[base % 64]}), 64'({1'b1, 27'd12}));
    chk(log_we[(base + 1) % 64] == 1'b0 && log_line[(base + 1) % 64] == 27'd52, "R5 fill after writeback",
        64'({log_we[(base + 1) % 64], log_line[(base + 1) % 64]}), 64'({1'b0, 27'd52}));
    chk(mem_img[12] == gold[12], "R5 victim contents in memory", 64'(mem_img[12][63:0]), 64'(gold[12][63:0]));
  endtask

  task automatic t_bulk_read();
    logic [255:0] rd;
    int base;
    base = log_n;
    cpu_op(1'b0, 2'd3, 90, 0, '0, rd);
    chk(rd == gold[90] && traffic(base) == 1, "R7 bulk read from memory", 64'(rd[63:0]), 64'(gold[90][63:0]));
    base = log_n;
    cpu_op(1'b0, 2'd2, 90, 0, '0, rd);
    chk(traffic(base) == 1, "R7 bulk read did not allocate", 64'(traffic(base)), 64'd1);
  endtask

  task automatic t_bulk_write_hit();
    logic [255:0] rd;
    logic [255:0] pat;
    int base;
    for (int b = 0; b < 32; b++) pat[b*8 +: 8] = 8'(8'hF0 ^ b);
    base = log_n;
    cpu_op(1'b1, 2'd3, 50, 0, pat, rd);
    chk(traffic(base) == 1 && log_we[base % 64] == 1'b1 && mem_img[50] == pat, "R8 bulk write reaches memory",
        64'(mem_img[50][63:0]), 64'(pat[63:0]));
    base = log_n;
    cpu_op(1'b0, 2'd2, 50, 12, '0, rd);
    chk(rd[31:0] == pat[12*8 +: 32] && traffic(base) == 0, "R8 resident copy refreshed",
        64'(rd[31:0]), 64'(pat[12*8 +: 32]));
  endtask

  task automatic t_bulk_read_dirty();
    logic [255:0] rd;
    int base;
    cpu_op(1'b1, 2'd0, 32, 9, 256'hC3, rd);
    base = log_n;
    cpu_op(1'b0, 2'd3, 32, 0, '0, rd);
    chk(traffic(base) == 0, "R9 dirty bulk read silent", 64'(traffic(base)), 64'd0);
    chk(rd == gold[32], "R9 dirty bulk data", 64'(rd[127:64]), 64'(gold[32][127:64]));
  endtask

  task automatic t_flush();
    logic [255:0] rd;
    int base;
    int t;
    int bad;
    base = log_n;
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    t = 0;
    while (!flush_done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 2000, "R10 flush completes", 64'(t), 64'd0);
    // dirty lines at this point: 3 and 32
    chk(traffic(base) == 2, "R10 dirty lines written", 64'(traffic(base)), 64'd2);
    bad = 0;
    for (int l = 0; l < NL; l++) if (mem_img[l] != gold[l]) bad++;
    chk(bad == 0, "R10 memory equals processor view", 64'(bad), 64'd0);
    base = log_n;
    cpu_op(1'b0, 2'd2, 7, 0, '0, rd);
    chk(traffic(base) == 1, "R10 lines invalid after flush", 64'(traffic(base)), 64'd1);
  endtask

  // ---------------- sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_alloc();
    t_sizes();
    t_write_alloc();
    t_set_map();
    t_dirty_wb();
    t_bulk_read();
    t_bulk_write_hit();
    t_bulk_read_dirty();
    t_flush();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1 watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

endmodule